// File: doc/BRIEF.md
# Latched GPIO Input Interrupt Unit

This unit watches sixteen general-purpose pins, split into two 8-bit ports. It keeps an input register that software reads one port at a time, and it pulls an active-low interrupt line when an enabled input pin changes. Every pin is compared with a reference level. That reference is the value the last host read of its port returned. The comparison tells the unit whether anything is pending.

Each pin has a latch-enable bit that selects its mode. With the bit clear, the pin is transparent. Its register bit shows the live synchronized level, and the pin is pending only while that level differs from the reference. If the pin goes back to the reference level, the interrupt goes away by itself. With the bit set, the first difference captures the new level and holds both the captured value and the pending state until the port is read, even if the pin goes back. A read strobe for a port returns the register value, records it as the new reference, and clears what was pending on that port.

After reset the pins pass through a two-flop synchronizer. A short warm-up loads the references from the synchronized levels, so leaving reset raises no interrupt. Latch-enable and mask each have a whole-vector write strobe.

Top module: `gpio_latch_irq`

## Requirements
- R1: After reset every latch-enable bit is 0 and every mask bit is 1. `int_n_o` stays high, and once the warm-up has finished no pin is pending while the pins are steady.
- R2: For an input pin (`dir_i` bit = 1) in transparent mode, `rd_data_o` shows the pin level two clock edges after the pin changes.
- R3: In transparent mode, a pin is pending while its synchronized level differs from its reference. If it returns to the reference before a read, it stops being pending with no read.
- R4: In latched mode, the first change captures the new level into its `rd_data_o` bit and makes the pin pending. If the pin returns to its original level, the bit keeps the captured level and the pin stays pending (0 to 1 to 0 still reads 1).
- R5: A pulse on `rd_port_i[p]` clears pending state only for pins of port p (bits 8p to 8p+7). It stores the value returned as the new reference, and after the read a latched bit follows the pin again.
- R6: `int_n_o` is low exactly when at least one pending pin has its mask bit at 0.
- R7: A pin with `dir_i` bit = 0 is never pending, and its latch-enable bit has no effect on it. `rd_data_o` shows its synchronized level, and switching it back to input raises no interrupt while the pin is steady.
- R8: If a pin's synchronized level changes at the same clock edge that samples a read strobe for its port, the read returns the old level and the pin is pending afterwards.
- R9: `cfg_latch_we_i` loads `cfg_latch_i` into the latch-enable bits, and `cfg_mask_we_i` loads `cfg_mask_i` into the mask bits (1 = masked), both at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 16 | Raw pin levels, port 1 in bits 15:8 |
| dir_i | input | 16 | Per-pin direction, 1 = input |
| cfg_latch_we_i | input | 1 | Write strobe for latch-enable bits |
| cfg_latch_i | input | 16 | New latch-enable bits |
| cfg_mask_we_i | input | 1 | Write strobe for mask bits |
| cfg_mask_i | input | 16 | New mask bits, 1 = masked |
| rd_port_i | input | 2 | Per-port read strobe |
| rd_data_o | output | 16 | Input register view |
| int_n_o | output | 1 | Active-low interrupt |

## Verification
The delicate collision is a pin's synchronized level changing at the same edge that samples a host read of its port. The bench provokes it by setting the pin one cycle before raising the read strobe, so that the second synchronizer stage turns over on the read edge. A second case has a latched pin that has already returned to its old level while it is being read. In both cases the bench expects the read to return the old value and the pin to be pending again in the next cycle. A behavioural reference model, compared every cycle, also judges many random overlaps of reads, pin changes, direction flips and configuration writes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned GPIO_PORT_W      = 8;
  localparam int unsigned GPIO_NUM_PORTS   = 2;
  localparam int unsigned GPIO_SYNC_STAGES = 2;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_track.sv
module gpio_pin_track (
  input  logic clk,
  input  logic rst_n,
  input  logic armed_i,
  input  logic lvl_i,
  input  logic is_in_i,
  input  logic latch_i,
  input  logic rd_i,
  output logic view_o,
  output logic pend_o,
  output logic hold_o
);
  logic ref_q, ref_d;
  logic hold_q, hold_d;
  logic cap_q, cap_d;
  logic cap_en;
  logic diff;
  logic show_cap;

  always_comb begin
    diff     = lvl_i ^ ref_q;
    show_cap = is_in_i & latch_i & hold_q;
    view_o   = show_cap ? cap_q : lvl_i;
    pend_o   = armed_i & is_in_i & (latch_i ? (hold_q | diff) : diff);
  end

  always_comb begin
    ref_d  = ref_q;
    hold_d = hold_q;
    cap_en = 1'b0;
    if (!armed_i || !is_in_i) begin
      ref_d  = lvl_i;
      hold_d = 1'b0;
    end else if (rd_i) begin
      ref_d  = view_o;
      hold_d = 1'b0;
    end else if (!latch_i) begin
      hold_d = 1'b0;
    end else if (!hold_q && diff) begin
      hold_d = 1'b1;
      cap_en = 1'b1;
    end
    cap_d = cap_en ? lvl_i : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      hold_q <= 1'b0;
      cap_q  <= 1'b0;
    end else begin
      ref_q  <= ref_d;
      hold_q <= hold_d;
      cap_q  <= cap_d;
    end
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/gpio_latch_irq.sv
module gpio_latch_irq
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PORT_W      = GPIO_PORT_W,
  parameter int unsigned NUM_PORTS   = GPIO_NUM_PORTS,
  parameter int unsigned SYNC_STAGES = GPIO_SYNC_STAGES
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [PORT_W*NUM_PORTS-1:0]   pin_i,
  input  logic [PORT_W*NUM_PORTS-1:0]   dir_i,
  input  logic                          cfg_latch_we_i,
  input  logic [PORT_W*NUM_PORTS-1:0]   cfg_latch_i,
  input  logic                          cfg_mask_we_i,
  input  logic [PORT_W*NUM_PORTS-1:0]   cfg_mask_i,
  input  logic [NUM_PORTS-1:0]          rd_port_i,
  output logic [PORT_W*NUM_PORTS-1:0]   rd_data_o,
  output logic                          int_n_o
);
  localparam int unsigned PIN_N   = PORT_W * NUM_PORTS;
  localparam int unsigned ARM_CYC = SYNC_STAGES + 1;
  localparam int unsigned CNT_W   = $clog2(ARM_CYC + 1);

  logic             rst_int_n;
  logic [PIN_N-1:0] lvl_sync;
  logic [PIN_N-1:0] latch_q, latch_d;
  logic [PIN_N-1:0] mask_q, mask_d;
  logic [CNT_W-1:0] arm_cnt_q, arm_cnt_d;
  logic             armed;
  logic [PIN_N-1:0] pend;
  logic [PIN_N-1:0] hold_vec;

  gpio_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  gpio_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (pin_i),
    .q_o   (lvl_sync)
  );

  always_comb begin
    armed     = (arm_cnt_q == CNT_W'(ARM_CYC));
    arm_cnt_d = armed ? arm_cnt_q : arm_cnt_q + CNT_W'(1);
    latch_d   = cfg_latch_we_i ? cfg_latch_i : latch_q;
    mask_d    = cfg_mask_we_i  ? cfg_mask_i  : mask_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      arm_cnt_q <= '0;
      latch_q   <= '0;
      mask_q    <= '1;
    end else begin
      arm_cnt_q <= arm_cnt_d;
      latch_q   <= latch_d;
      mask_q    <= mask_d;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
      localparam int unsigned IDX = p * PORT_W + b;
      gpio_pin_track u_pin (
        .clk     (clk),
        .rst_n   (rst_int_n),
        .armed_i (armed),
        .lvl_i   (lvl_sync[IDX]),
        .is_in_i (dir_i[IDX]),
        .latch_i (latch_q[IDX]),
        .rd_i    (rd_port_i[p]),
        .view_o  (rd_data_o[IDX]),
        .pend_o  (pend[IDX]),
        .hold_o  (hold_vec[IDX])
      );
    end
  end

  assign int_n_o = ~|(pend & ~mask_q);
endmodule

// File: rtl/gpio_latch_irq_chk.sv
module gpio_latch_irq_chk #(
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned NUM_PORTS = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        armed,
  input logic [PORT_W*NUM_PORTS-1:0] dir_i,
  input logic [PORT_W*NUM_PORTS-1:0] latch_q,
  input logic [PORT_W*NUM_PORTS-1:0] mask_q,
  input logic [PORT_W*NUM_PORTS-1:0] hold_q,
  input logic                        latch_we,
  input logic [NUM_PORTS-1:0]        rd_port_i,
  input logic [PORT_W*NUM_PORTS-1:0] rd_data_o,
  input logic                        int_n_o
);
  // R1: nothing can interrupt during warm-up
  a_r1_warmup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> int_n_o);

  // R6: all pins masked keeps the line high
  a_r6_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> int_n_o);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
    // R5: a read leaves no captured state on that port
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rd_port_i[p] |=> ~|hold_q[p*PORT_W +: PORT_W]);
    for (genvar b = 0; b < PORT_W; b++) begin : g_b
      localparam int unsigned I = p * PORT_W + b;
      // R4: a held capture does not move until read
      a_r4_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && dir_i[I] && latch_q[I] && hold_q[I] && !rd_port_i[p] && !latch_we)
        |=> (!dir_i[I] || $stable(rd_data_o[I])));
      // R7: output pins never hold a capture
      a_r7_output_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_i[I] |=> !hold_q[I]);
    end
  end
endmodule

bind gpio_latch_irq gpio_latch_irq_chk #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .armed     (armed),
  .dir_i     (dir_i),
  .latch_q   (latch_q),
  .mask_q    (mask_q),
  .hold_q    (hold_vec),
  .latch_we  (cfg_latch_we_i),
  .rd_port_i (rd_port_i),
  .rd_data_o (rd_data_o),
  .int_n_o   (int_n_o)
);

// File: tb/gpio_latch_irq_tb.sv
module gpio_latch_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  pin, dir, cl, cm, rd_data;
  logic          cl_we, cm_we, int_n;
  logic [1:0]    rd;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_latch_irq u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .dir_i(dir),
    .cfg_latch_we_i(cl_we), .cfg_latch_i(cl),
    .cfg_mask_we_i(cm_we), .cfg_mask_i(cm),
    .rd_port_i(rd), .rd_data_o(rd_data), .int_n_o(int_n)
  );

  // behavioural reference model
  logic [N-1:0] m_s1, m_s2, m_ref, m_hold, m_cap, m_le, m_mask;
  int m_rs, m_arm;

  function automatic logic [N-1:0] m_view();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++)
      v[i] = (dir[i] && m_le[i] && m_hold[i]) ? m_cap[i] : m_s2[i];
    return v;
  endfunction

  function automatic logic m_int_n();
    for (int i = 0; i < N; i++) begin
      logic pnd;
      pnd = 1'b0;
      if (m_arm == 3 && dir[i]) begin
        if (m_s2[i] != m_ref[i]) pnd = 1'b1;
        if (m_le[i] && m_hold[i]) pnd = 1'b1;
      end
      if (pnd && !m_mask[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_ref = '0; m_hold = '0; m_cap = '0;
      m_le = '0; m_mask = '1; m_rs = 0; m_arm = 0;
    end else if (m_rs < 2) begin
      m_rs = m_rs + 1;
    end else begin
      logic [N-1:0] v;
      v = m_view();
      for (int i = 0; i < N; i++) begin
        if (m_arm != 3 || !dir[i]) begin
          m_ref[i] = m_s2[i]; m_hold[i] = 1'b0;
        end else if (rd[i/8]) begin
          m_ref[i] = v[i]; m_hold[i] = 1'b0;
        end else if (!m_le[i]) begin
          m_hold[i] = 1'b0;
        end else if (!m_hold[i] && m_s2[i] != m_ref[i]) begin
          m_hold[i] = 1'b1; m_cap[i] = m_s2[i];
        end
      end
      if (m_arm < 3) m_arm = m_arm + 1;
      if (cl_we) m_le = cl;
      if (cm_we) m_mask = cm;
      m_s2 = m_s1;
      m_s1 = pin;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0] ev;
      logic ei;
      ev = m_view();
      ei = m_int_n();
      total++;
      if (rd_data !== ev || int_n !== ei) begin
        bad++;
        $display("FAIL %s model: rd_data=%h int_n=%b expected rd_data=%h int_n=%b",
                 cur_req, rd_data, int_n, ev, ei);
      end
    end
  end

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic read_port(input int p);
    rd[p] = 1'b1; tick(1); rd = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin = 16'h00A5; dir = '1; cl = '0; cm = '0;
    cl_we = 0; cm_we = 0; rd = '0;
    #(3*CLK_PERIOD + 1);
    rst_n = 1'b1;
    tick(10);
    // R1: quiet after reset, register shows pins
    cur_req = "R1";
    chk("R1 int", {15'd0, int_n}, 16'd1);
    chk("R1 data", rd_data, 16'h00A5);
    // R9: unmask all
    cur_req = "R9";
    cm = '0; cm_we = 1; tick(1); cm_we = 0; tick(2);
    chk("R9 unmask steady", {15'd0, int_n}, 16'd1);
    // R2/R3: transparent change then return
    cur_req = "R2";
    pin[0] = 1'b0; tick(1);
    chk("R2 not yet", rd_data, 16'h00A5);
    tick(2);
    chk("R2 follows", rd_data, 16'h00A4);
    cur_req = "R3";
    chk("R3 pending", {15'd0, int_n}, 16'd0);
    pin[0] = 1'b1; tick(3);
    chk("R3 self cancel", {15'd0, int_n}, 16'd1);
    // R5: port-local clear
    cur_req = "R5";
    pin[8] = 1'b1; tick(3);
    chk("R5 p1 pending", {15'd0, int_n}, 16'd0);
    read_port(0); tick(2);
    chk("R5 p0 read keeps p1", {15'd0, int_n}, 16'd0);
    read_port(1); tick(2);
    chk("R5 p1 read clears", {15'd0, int_n}, 16'd1);
    chk("R5 data", rd_data, 16'h01A5);
    // R4: latched glitch 0->1->0
    cur_req = "R4";
    cl = 16'h0002; cl_we = 1; tick(1); cl_we = 0;
    pin[1] = 1'b1; tick(4);
    pin[1] = 1'b0; tick(4);
    chk("R4 held value", rd_data, 16'h01A7);
    chk("R4 held pending", {15'd0, int_n}, 16'd0);
    read_port(0); tick(2);
    cur_req = "R5";
    chk("R5 new capture after read", rd_data, 16'h01A5);
    chk("R5 re-pend after read", {15'd0, int_n}, 16'd0);
    read_port(0); tick(2);
    chk("R5 cleared", {15'd0, int_n}, 16'd1);
    // R8: change at the read edge
    cur_req = "R8";
    pin[2] = 1'b0; tick(1);
    read_port(0); tick(2);
    chk("R8 pending after collide", {15'd0, int_n}, 16'd0);
    read_port(0); tick(2);
    chk("R8 cleared", {15'd0, int_n}, 16'd1);
    // R7: output direction pins
    cur_req = "R7";
    dir[3] = 1'b0; cl = 16'h000A; cl_we = 1; tick(1); cl_we = 0;
    pin[3] = 1'b1; tick(4);
    chk("R7 no irq", {15'd0, int_n}, 16'd1);
    chk("R7 data follows", rd_data & 16'h0008, 16'h0008);
    pin[3] = 1'b0; tick(4);
    chk("R7 data follows back", rd_data & 16'h0008, 16'h0000);
    dir[3] = 1'b1; tick(3);
    chk("R7 back to input quiet", {15'd0, int_n}, 16'd1);
    // R6/R9: mask gating
    cur_req = "R6";
    pin[4] = 1'b1; tick(3);
    chk("R6 pending", {15'd0, int_n}, 16'd0);
    cm = 16'h0010; cm_we = 1; tick(1); cm_we = 0;
    chk("R6 masked", {15'd0, int_n}, 16'd1);
    cm = 16'h0000; cm_we = 1; tick(1); cm_we = 0;
    chk("R6 unmasked", {15'd0, int_n}, 16'd0);
    read_port(0); tick(2);
    chk("R6 read clears", {15'd0, int_n}, 16'd1);
    // random mix, judged by the model every cycle
    cur_req = "R2/R3/R4/R5/R8";
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 3) == 0) pin = pin ^ (16'd1 << $urandom_range(0, 15));
      rd = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
      if ($urandom_range(0, 60) == 0) dir = dir ^ (16'd1 << $urandom_range(0, 15));
      cl_we = ($urandom_range(0, 80) == 0);
      cl = 16'($urandom);
      cm_we = ($urandom_range(0, 80) == 0);
      cm = 16'($urandom) & 16'($urandom);
      tick(1);
    end
    rd = '0; cl_we = 0; cm_we = 0;
    tick(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule